// File: doc/BRIEF.md
# Synthesizer Divider Programming Interface

This block holds the divider configuration of a frequency synthesizer and presents it to the counter logic as a set of control fields: a 9-bit M count, a 6-bit R count, a 4-bit A count, a prescaler bypass bit and an 8-bit enhancement byte. The configuration can be loaded through a serial shift port, through a byte-wide parallel port with a separate write strobe for each field group, or supplied directly from input pins with no register in the path.

Two 20-bit configuration words are kept. The working word is filled by either loading port. A transfer strobe copies it as a whole into a second, held word. A select input then chooses which of the two words drives the divider outputs. Software can therefore preload a new setting and switch to it in a single step. Every strobe, the serial clock and the serial data are brought into the system clock domain through a two-flop synchronizer. Strobes act on their rising edges, detected in that domain.

Top module: `synth_div_cfg`

## Requirements
- R1: A synchronous reset clears the working word, the held word and the enhancement byte to zero. After reset, the outputs in parallel mode are all zero whichever word is selected.
- R2: The port is selected by two mode inputs. `mode_direct_i`=1 selects direct mode. `mode_direct_i`=0 with `mode_serial_i`=1 selects serial mode. Both at 0 selects parallel mode. Leaving direct mode brings back the stored words unchanged.
- R3: In serial mode with `enh_wr_i` low, each rising edge of `ser_clk_i` while `ser_load_n_i` is low shifts `ser_data_i` into the working word. The word is sent MSB first. Its layout from bit 19 down is: prescaler bypass, M[8:0], R[5:0], A[3:0].
- R4: In serial mode with `enh_wr_i` high, the rising edges of `ser_clk_i` shift data MSB first into the 8-bit enhancement byte instead, and the working word is left unchanged.
- R5: The working word is copied into the held word on a rising edge of `hop_wr_i` in serial or parallel mode. It is also copied on a rising edge of `ser_load_n_i` in serial mode. Without such an edge the held word does not change.
- R6: A select value of 1 drives the outputs from the working word and 0 from the held word. `sel_ser_i` is the select in serial mode and `sel_par_i` in parallel mode.
- R7: In parallel mode, a rising edge of `m_lo_wr_i` loads `pdata_i[7]` into the prescaler bypass bit and `pdata_i[6:0]` into M[6:0].
- R8: In parallel mode, a rising edge of `m_hi_wr_i` loads `pdata_i[3:2]` into R[5:4] and `pdata_i[1:0]` into M[8:7].
- R9: In parallel mode, a rising edge of `a_wr_i` loads `pdata_i[7:4]` into R[3:0] and `pdata_i[3:0]` into A[3:0].
- R10: In parallel mode, a rising edge of `enh_wr_i` loads `pdata_i[7:0]` into the enhancement byte.
- R11: In direct mode the outputs come straight from the pins, as follows. The prescaler bypass is `pdata_i[7]`. M is {2'b00, `pdata_i[6:0]`}. R is zero. A is `dir_a_i`. The enhancement output keeps showing the stored byte.
- R12: In serial mode, `ser_clk_i` edges while `ser_load_n_i` is high change nothing.
- R13: In serial mode the parallel field strobes have no effect, and a rising `enh_wr_i` does not load the enhancement byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_direct_i | input | 1 | 1 selects direct mode |
| mode_serial_i | input | 1 | Serial (1) or parallel (0) when not direct |
| ser_clk_i | input | 1 | Serial shift clock |
| ser_data_i | input | 1 | Serial data, MSB first |
| ser_load_n_i | input | 1 | Shift enable when low; rising edge copies working to held word |
| enh_wr_i | input | 1 | Serial: steer shifts to enhancement byte; parallel: enhancement write strobe |
| hop_wr_i | input | 1 | Rising edge copies working word into held word |
| m_lo_wr_i | input | 1 | Parallel strobe for bypass bit and M[6:0] |
| m_hi_wr_i | input | 1 | Parallel strobe for R[5:4] and M[8:7] |
| a_wr_i | input | 1 | Parallel strobe for R[3:0] and A[3:0] |
| sel_ser_i | input | 1 | Word select in serial mode (1 = working) |
| sel_par_i | input | 1 | Word select in parallel mode (1 = working) |
| pdata_i | input | 8 | Parallel data byte, also direct-mode pins |
| dir_a_i | input | 4 | Direct-mode A count |
| pre_bypass_o | output | 1 | Prescaler bypass (1 = bypass) |
| m_cnt_o | output | 9 | M count |
| r_cnt_o | output | 6 | R count |
| a_cnt_o | output | 4 | A count |
| enh_o | output | 8 | Enhancement byte |

## Verification
The bench sweeps many arithmetic word patterns through each loading path. After each sweep it checks both the working and the held word through the select inputs, so a field routed to the wrong bits or a reversed serial order shows up as a mismatched count. It checks the held word just before and just after each transfer edge. A design that copies on the wrong edge, or copies continuously, shows the new word too early. Clock edges while the load enable is high, and parallel strobes in serial mode, must leave the outputs unchanged; a design that ignores its gating would corrupt them. A direct-mode sweep over all data byte values confirms the pin mapping. Returning to parallel mode afterwards shows that the stored words survived.

// File: rtl/div_cfg_pkg.sv
package div_cfg_pkg;

    localparam int M_W     = 9;
    localparam int R_W     = 6;
    localparam int A_W     = 4;
    localparam int ENH_W   = 8;
    localparam int DATA_W  = 8;
    localparam int WORD_W  = 1 + M_W + R_W + A_W;
    localparam int SYNC_STAGES = 2;

    // indices into the synchronized input vector
    localparam int IX_SCLK   = 0;
    localparam int IX_SDATA  = 1;
    localparam int IX_LOADN  = 2;
    localparam int IX_ENH    = 3;
    localparam int IX_HOP    = 4;
    localparam int IX_MLO    = 5;
    localparam int IX_MHI    = 6;
    localparam int IX_AWR    = 7;
    localparam int IX_MDIR   = 8;
    localparam int IX_MSER   = 9;
    localparam int IX_SSEL   = 10;
    localparam int IX_PSEL   = 11;
    localparam int IX_PDATA  = 12;
    localparam int IX_DIRA   = IX_PDATA + DATA_W;
    localparam int SYNC_W    = IX_DIRA + A_W;

    typedef struct packed {
        logic           pre;   // 1 = prescaler bypassed
        logic [M_W-1:0] m;
        logic [R_W-1:0] r;
        logic [A_W-1:0] a;
    } div_word_t;

    typedef enum logic [1:0] {
        PM_PAR = 2'd0,
        PM_SER = 2'd1,
        PM_DIR = 2'd2
    } port_mode_e;

    function automatic port_mode_e decode_mode(logic dir, logic ser);
        if (dir)      return PM_DIR;
        else if (ser) return PM_SER;
        else          return PM_PAR;
    endfunction

    function automatic div_word_t put_m_lo(div_word_t w, logic [DATA_W-1:0] d);
        div_word_t n = w;
        n.pre    = d[7];
        n.m[6:0] = d[6:0];
        return n;
    endfunction

    function automatic div_word_t put_m_hi(div_word_t w, logic [DATA_W-1:0] d);
        div_word_t n = w;
        n.r[5:4] = d[3:2];
        n.m[8:7] = d[1:0];
        return n;
    endfunction

    function automatic div_word_t put_a(div_word_t w, logic [DATA_W-1:0] d);
        div_word_t n = w;
        n.r[3:0] = d[7:4];
        n.a      = d[3:0];
        return n;
    endfunction

endpackage

// File: rtl/div_cfg_sync.sv
module div_cfg_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] stg [STAGES];
    logic [W-1:0] prev_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[0] <= '0;
                    else     stg[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[g] <= '0;
                    else     stg[g] <= stg[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= stg[STAGES-1];
    end

    assign lvl_o  = stg[STAGES-1];
    assign rise_o = stg[STAGES-1] & ~prev_q;
endmodule

// File: rtl/div_cfg_regs.sv
module div_cfg_regs
    import div_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  port_mode_e        mode,
    input  logic              sdata,
    input  logic              load_n_lvl,
    input  logic              enh_lvl,
    input  logic              sclk_rise,
    input  logic              load_rise,
    input  logic              hop_rise,
    input  logic              mlo_rise,
    input  logic              mhi_rise,
    input  logic              a_rise,
    input  logic              enh_rise,
    input  logic [DATA_W-1:0] pdata,
    output div_word_t         prim_o,
    output div_word_t         sec_o,
    output logic [ENH_W-1:0]  enh_o
);
    div_word_t        prim_q, sec_q;
    logic [ENH_W-1:0] enh_q;

    logic shift_en;
    assign shift_en = (mode == PM_SER) && sclk_rise && !load_n_lvl;

    // working word
    always_ff @(posedge clk) begin
        if (rst) begin
            prim_q <= '0;
        end else if (shift_en && !enh_lvl) begin
            prim_q <= div_word_t'({prim_q[WORD_W-2:0], sdata});
        end else if (mode == PM_PAR) begin
            if (mlo_rise)      prim_q <= put_m_lo(prim_q, pdata);
            else if (mhi_rise) prim_q <= put_m_hi(prim_q, pdata);
            else if (a_rise)   prim_q <= put_a(prim_q, pdata);
        end
    end

    // enhancement byte
    always_ff @(posedge clk) begin
        if (rst) begin
            enh_q <= '0;
        end else if (shift_en && enh_lvl) begin
            enh_q <= {enh_q[ENH_W-2:0], sdata};
        end else if (mode == PM_PAR && enh_rise) begin
            enh_q <= pdata;
        end
    end

    // held word: whole-word transfer
    logic xfer;
    assign xfer = (mode != PM_DIR) && (hop_rise || (mode == PM_SER && load_rise));

    always_ff @(posedge clk) begin
        if (rst)       sec_q <= '0;
        else if (xfer) sec_q <= prim_q;
    end

    assign prim_o = prim_q;
    assign sec_o  = sec_q;
    assign enh_o  = enh_q;
endmodule

// File: rtl/div_cfg_outsel.sv
module div_cfg_outsel
    import div_cfg_pkg::*;
(
    input  port_mode_e        mode,
    input  logic              sel_ser,
    input  logic              sel_par,
    input  div_word_t         prim,
    input  div_word_t         sec,
    input  logic [DATA_W-1:0] pins_d,
    input  logic [A_W-1:0]    pins_a,
    output div_word_t         word_o
);
    always_comb begin
        word_o = '0;
        unique case (mode)
            PM_DIR: begin
                word_o.pre    = pins_d[7];
                word_o.m[6:0] = pins_d[6:0];
                word_o.a      = pins_a;
            end
            PM_SER:  word_o = sel_ser ? prim : sec;
            default: word_o = sel_par ? prim : sec;
        endcase
    end
endmodule

// File: rtl/synth_div_cfg.sv
module synth_div_cfg
    import div_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_direct_i,
    input  logic              mode_serial_i,
    input  logic              ser_clk_i,
    input  logic              ser_data_i,
    input  logic              ser_load_n_i,
    input  logic              enh_wr_i,
    input  logic              hop_wr_i,
    input  logic              m_lo_wr_i,
    input  logic              m_hi_wr_i,
    input  logic              a_wr_i,
    input  logic              sel_ser_i,
    input  logic              sel_par_i,
    input  logic [DATA_W-1:0] pdata_i,
    input  logic [A_W-1:0]    dir_a_i,
    output logic              pre_bypass_o,
    output logic [M_W-1:0]    m_cnt_o,
    output logic [R_W-1:0]    r_cnt_o,
    output logic [A_W-1:0]    a_cnt_o,
    output logic [ENH_W-1:0]  enh_o
);
    logic [SYNC_W-1:0] raw, lvl, rise;

    always_comb begin
        raw = '0;
        raw[IX_SCLK]  = ser_clk_i;
        raw[IX_SDATA] = ser_data_i;
        raw[IX_LOADN] = ser_load_n_i;
        raw[IX_ENH]   = enh_wr_i;
        raw[IX_HOP]   = hop_wr_i;
        raw[IX_MLO]   = m_lo_wr_i;
        raw[IX_MHI]   = m_hi_wr_i;
        raw[IX_AWR]   = a_wr_i;
        raw[IX_MDIR]  = mode_direct_i;
        raw[IX_MSER]  = mode_serial_i;
        raw[IX_SSEL]  = sel_ser_i;
        raw[IX_PSEL]  = sel_par_i;
        raw[IX_PDATA +: DATA_W] = pdata_i;
        raw[IX_DIRA  +: A_W]    = dir_a_i;
    end

    div_cfg_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_i(raw), .lvl_o(lvl), .rise_o(rise)
    );

    port_mode_e mode;
    assign mode = decode_mode(lvl[IX_MDIR], lvl[IX_MSER]);

    div_word_t        prim_q, sec_q, out_w;
    logic [ENH_W-1:0] enh_q;

    div_cfg_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .sdata      (lvl[IX_SDATA]),
        .load_n_lvl (lvl[IX_LOADN]),
        .enh_lvl    (lvl[IX_ENH]),
        .sclk_rise  (rise[IX_SCLK]),
        .load_rise  (rise[IX_LOADN]),
        .hop_rise   (rise[IX_HOP]),
        .mlo_rise   (rise[IX_MLO]),
        .mhi_rise   (rise[IX_MHI]),
        .a_rise     (rise[IX_AWR]),
        .enh_rise   (rise[IX_ENH]),
        .pdata      (lvl[IX_PDATA +: DATA_W]),
        .prim_o     (prim_q),
        .sec_o      (sec_q),
        .enh_o      (enh_q)
    );

    div_cfg_outsel u_outsel (
        .mode    (mode),
        .sel_ser (lvl[IX_SSEL]),
        .sel_par (lvl[IX_PSEL]),
        .prim    (prim_q),
        .sec     (sec_q),
        .pins_d  (lvl[IX_PDATA +: DATA_W]),
        .pins_a  (lvl[IX_DIRA +: A_W]),
        .word_o  (out_w)
    );

    assign pre_bypass_o = out_w.pre;
    assign m_cnt_o      = out_w.m;
    assign r_cnt_o      = out_w.r;
    assign a_cnt_o      = out_w.a;
    assign enh_o        = enh_q;
endmodule

// File: rtl/div_cfg_chk.sv
module div_cfg_chk
    import div_cfg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input port_mode_e        mode,
    input div_word_t         prim,
    input div_word_t         sec,
    input logic [ENH_W-1:0]  enh,
    input logic [SYNC_W-1:0] lvl,
    input logic [SYNC_W-1:0] rise
);
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (prim == '0 && sec == '0 && enh == '0));

    p_ser_shift_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_SER && rise[IX_SCLK] && !lvl[IX_LOADN] && !lvl[IX_ENH])
        |=> (prim[0] == $past(lvl[IX_SDATA]) && prim[WORD_W-1:1] == $past(prim[WORD_W-2:0])));

    p_sec_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !(rise[IX_HOP] || rise[IX_LOADN]) |=> $stable(sec));

    p_sec_copy_r5: assert property (@(posedge clk) disable iff (rst)
        (rise[IX_HOP] && mode == PM_PAR) |=> (sec == $past(prim)));

    p_prim_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !(rise[IX_SCLK] || rise[IX_MLO] || rise[IX_MHI] || rise[IX_AWR]) |=> $stable(prim));

    p_enh_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !(rise[IX_SCLK] || rise[IX_ENH]) |=> $stable(enh));

    p_ser_no_strobe_r13: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_SER && !rise[IX_SCLK]) |=> $stable(prim) && $stable(enh));
endmodule

bind synth_div_cfg div_cfg_chk u_chk (
    .clk  (clk),
    .rst  (rst),
    .mode (mode),
    .prim (prim_q),
    .sec  (sec_q),
    .enh  (enh_q),
    .lvl  (lvl),
    .rise (rise)
);

// File: tb/tb_synth_div_cfg.sv
module tb_synth_div_cfg;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_direct = 0, mode_serial = 0;
    logic ser_clk = 0, ser_data = 0, ser_load_n = 1, enh_wr = 0, hop_wr = 0;
    logic m_lo_wr = 0, m_hi_wr = 0, a_wr = 0, sel_ser = 1, sel_par = 1;
    logic [7:0] pdata = 0;
    logic [3:0] dir_a = 0;
    logic       pre_bypass;
    logic [8:0] m_cnt;
    logic [5:0] r_cnt;
    logic [3:0] a_cnt;
    logic [7:0] enh_out;

    int checks = 0, failures = 0;
    bit done = 0;

    // reference model state (layout: bit19 bypass, 18:10 M, 9:4 R, 3:0 A)
    logic [19:0] x_prim = 0, x_sec = 0;
    logic [7:0]  x_enh = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    synth_div_cfg dut (
        .clk(clk), .rst(rst),
        .mode_direct_i(mode_direct), .mode_serial_i(mode_serial),
        .ser_clk_i(ser_clk), .ser_data_i(ser_data), .ser_load_n_i(ser_load_n),
        .enh_wr_i(enh_wr), .hop_wr_i(hop_wr),
        .m_lo_wr_i(m_lo_wr), .m_hi_wr_i(m_hi_wr), .a_wr_i(a_wr),
        .sel_ser_i(sel_ser), .sel_par_i(sel_par),
        .pdata_i(pdata), .dir_a_i(dir_a),
        .pre_bypass_o(pre_bypass), .m_cnt_o(m_cnt), .r_cnt_o(r_cnt),
        .a_cnt_o(a_cnt), .enh_o(enh_out)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [19:0] w, input logic [7:0] e);
        logic [27:0] act, exp;
        act = {pre_bypass, m_cnt, r_cnt, a_cnt, enh_out};
        exp = {w, e};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%07h expected=%07h", tag, act, exp);
        end
    endtask

    task automatic pstrobe(input int which, input logic [7:0] d);
        pdata = d; cyc(3);
        case (which)
            0: m_lo_wr = 1; 1: m_hi_wr = 1; 2: a_wr = 1; 3: enh_wr = 1; default: hop_wr = 1;
        endcase
        cyc(3);
        m_lo_wr = 0; m_hi_wr = 0; a_wr = 0; enh_wr = 0; hop_wr = 0;
        cyc(3);
    endtask

    task automatic sbit(input logic b);
        ser_data = b; cyc(3);
        ser_clk = 1;  cyc(3);
        ser_clk = 0;  cyc(3);
    endtask

    task automatic set_sel(input logic s);
        sel_ser = s; sel_par = s; cyc(5);
    endtask

    initial begin
        cyc(WATCHDOG);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        cyc(4);
        rst = 0;
        cyc(6);
        // R1: reset state, both words
        set_sel(1); chk("R1 working after reset", 20'h0, 8'h0);
        set_sel(0); chk("R1 held after reset", 20'h0, 8'h0);

        // parallel sweep
        for (int i = 0; i < 24; i++) begin
            logic [7:0] dl, dh, da, de;
            dl = 8'(i * 37 + 5);
            dh = 8'(i * 11 + 3);
            da = 8'(i * 53 + 9);
            de = 8'(i * 29 + 1);
            pstrobe(0, dl);
            x_prim[19] = dl[7]; x_prim[16:10] = dl[6:0];
            pstrobe(1, dh);
            x_prim[18:17] = dh[1:0]; x_prim[9:8] = dh[3:2];
            pstrobe(2, da);
            x_prim[7:4] = da[7:4]; x_prim[3:0] = da[3:0];
            set_sel(1); chk("R7 R8 R9 parallel fields", x_prim, x_enh);
            set_sel(0); chk("R6 held before hop", x_sec, x_enh);
            pstrobe(4, 8'h00); x_sec = x_prim;
            chk("R5 held after hop", x_sec, x_enh);
            pstrobe(3, de); x_enh = de;
            chk("R10 parallel enhancement", x_sec, x_enh);
        end

        // serial mode
        mode_serial = 1; cyc(5);
        for (int i = 0; i < 12; i++) begin
            logic [19:0] w;
            w = 20'(i * 32'h2F1B3 + 32'h1234);
            ser_load_n = 0; cyc(3);
            for (int b = 19; b >= 0; b--) sbit(w[b]);
            x_prim = w;
            set_sel(1); chk("R3 serial word MSB first", x_prim, x_enh);
            set_sel(0); chk("R6 R5 held unchanged while loading", x_sec, x_enh);
            if (i % 2 == 1) begin
                pstrobe(4, 8'h00); x_sec = x_prim;
                chk("R5 hop in serial mode", x_sec, x_enh);
            end
            ser_load_n = 1; cyc(5); x_sec = x_prim;
            chk("R5 load enable rise copies", x_sec, x_enh);
        end

        // R4: serial enhancement load
        for (int i = 0; i < 4; i++) begin
            logic [7:0] e;
            e = 8'(i * 71 + 13);
            enh_wr = 1; cyc(3);
            ser_load_n = 0; cyc(3);
            for (int b = 7; b >= 0; b--) sbit(e[b]);
            ser_load_n = 1; cyc(3);
            enh_wr = 0; cyc(5);
            x_enh = e; x_sec = x_prim;
            set_sel(1); chk("R4 serial enhancement, working word kept", x_prim, x_enh);
        end

        // R12: clocks with load enable high are ignored
        for (int b = 0; b < 20; b++) sbit(~x_prim[b]);
        chk("R12 clocks ignored while load high", x_prim, x_enh);

        // R13: parallel strobes ignored in serial mode
        pstrobe(0, ~x_prim[19:12]);
        pstrobe(1, 8'hFF);
        pstrobe(2, ~x_prim[7:0]);
        pstrobe(3, ~x_enh);
        chk("R13 parallel strobes ignored in serial", x_prim, x_enh);

        // R11: direct mode sweep
        mode_direct = 1; cyc(5);
        for (int v = 0; v < 256; v++) begin
            pdata = 8'(v); dir_a = 4'(v * 7 + 1); cyc(5);
            chk("R11 direct pins", {pdata[7], 2'b00, pdata[6:0], 6'b0, dir_a}, x_enh);
        end

        // R2: back to parallel, stored words intact
        mode_direct = 0; mode_serial = 0; cyc(5);
        set_sel(1); chk("R2 working kept across modes", x_prim, x_enh);
        set_sel(0); chk("R2 held kept across modes", x_sec, x_enh);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule